// File: doc/BRIEF.md
# Interrupt Exception Entry Sequencer

This block owns the program counter and the current status word of a small 32-bit processor state model, together with a banked link register and a banked saved-status register that belong to interrupt mode. An interrupt is taken only when three things hold: the request is high, the core marks an instruction boundary, and the interrupt-disable bit of the status word is clear. When it is taken, the block stores a return address and the old status word in the banked pair. It then switches the status word into interrupt mode with interrupts disabled, points the program counter at a fixed vector and pulses a flush so that the fetch path discards what it prefetched.

A return strobe reverses the entry in a single clock edge. The program counter becomes the banked link value less four, and the status word is reloaded from the saved copy in the same edge. Outside these two events the surrounding core may write the program counter and the status word through plain write ports. Instruction decode and the general register file are outside this block.

Top module: `irq_entry_seq`

## Requirements
- R1: While reset is high, and afterwards until another event changes them, the program counter is 0, the link and saved-status registers are 0, flush is low, and the status word is 32'h0000_0093: mode field bits [4:0] = 5'b10011 (supervisor), interrupt-disable bit 7 = 1, all other bits 0.
- R2: An entry happens at a clock edge only if the request, the boundary strobe and a clear bit 7 of the status word are all present at that edge. In every other case the request changes no output.
- R3: On entry the link register receives the program counter value held before the edge plus 4, modulo 2^32.
- R4: On entry the saved-status register receives the status word held before the edge.
- R5: After entry the status word has bits [4:0] = 5'b10010 (interrupt mode) and bit 7 = 1. All of its other bits keep their previous values.
- R6: After entry the program counter equals 32'h0000_0018.
- R7: Flush is high for exactly the one cycle that follows an entry edge and is low at all other times.
- R8: A return strobe seen while bits [4:0] of the status word equal 5'b10010 sets the program counter to the link value minus 4 and the status word to the saved-status value, both at the same edge.
- R9: A return strobe seen while the mode field is anything other than 5'b10010 has no effect.
- R10: Priority at one edge is entry first, then return, then the program counter and status word write ports. A write port takes effect at the next edge only when neither entry nor return occurs.
- R11: The link and saved-status registers change only on entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Interrupt request level |
| insn_boundary | input | 1 | High when the core sits between instructions |
| ret_req | input | 1 | Strobe for the return from interrupt |
| pc_wr_en | input | 1 | Write enable for the program counter |
| pc_wr_data | input | 32 | New program counter value |
| psr_wr_en | input | 1 | Write enable for the status word |
| psr_wr_data | input | 32 | New status word value |
| pc | output | 32 | Program counter (address of the next instruction) |
| cpsr | output | 32 | Current status word |
| irq_link | output | 32 | Banked interrupt-mode link register |
| irq_spsr | output | 32 | Banked interrupt-mode saved status word |
| flush | output | 1 | One-cycle pulse that discards prefetched instructions |

## Verification
Every result is registered once, so every effect of entry, return or a write port shows on the outputs in the cycle right after the edge where its inputs were present. The flush pulse is due in that same cycle and must be gone one cycle later. The bench drives its inputs on the falling edge and keeps a behavioural model that it advances on each rising edge. It compares all five outputs with that model at the following falling edge, so each comparison looks at the state one edge after the stimulus. Directed cases cover the masked request, the missing boundary, a return outside interrupt mode, a return and a write at the same edge, and the link wrap-around. A long random phase then mixes all inputs.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int unsigned MODE_W = 5;
  typedef logic [MODE_W-1:0] mode_t;
  localparam mode_t MODE_IRQ = 5'b10010;
  localparam mode_t MODE_SVC = 5'b10011;

  // Status word as it appears after the interrupt is accepted.
  function automatic logic [31:0] psr_after_entry(input logic [31:0] cur, input int unsigned ibit);
    logic [31:0] r;
    r = cur;
    r[MODE_W-1:0] = MODE_IRQ;
    r[ibit] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] psr_at_reset(input int unsigned ibit);
    logic [31:0] r;
    r = '0;
    r[MODE_W-1:0] = MODE_SVC;
    r[ibit] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/irq_take_detect.sv
module irq_take_detect
  import irq_seq_pkg::*;
(
  input  logic  irq_req,
  input  logic  insn_boundary,
  input  logic  ret_req,
  input  logic  irq_masked,
  input  mode_t cur_mode,
  output logic  take,
  output logic  ret_fire
);
  // Entry wins over a return seen at the same edge.
  always_comb begin
    take     = irq_req && insn_boundary && !irq_masked;
    ret_fire = ret_req && !take && (cur_mode == MODE_IRQ);
  end
endmodule

// File: rtl/irq_bank_regs.sv
module irq_bank_regs #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned PC_STEP = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic [XLEN-1:0] pc_q,
  input  logic [XLEN-1:0] cpsr_q,
  output logic [XLEN-1:0] link_q,
  output logic [XLEN-1:0] spsr_q
);
  localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      link_q <= '0;
      spsr_q <= '0;
    end else if (take) begin
      link_q <= pc_q + STEP;
      spsr_q <= cpsr_q;
    end
  end

  AST_LINK_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    take |=> link_q == $past(pc_q) + STEP); // R3
  AST_SPSR_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    take |=> spsr_q == $past(cpsr_q)); // R4
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(link_q) && $stable(spsr_q)); // R11
endmodule

// File: rtl/irq_psr_pc_unit.sv
module irq_psr_pc_unit
  import irq_seq_pkg::*;
#(
  parameter int unsigned     XLEN        = 32,
  parameter int unsigned     PC_STEP     = 4,
  parameter int unsigned     IBIT_POS    = 7,
  parameter logic [XLEN-1:0] VECTOR_ADDR = 32'h0000_0018,
  parameter logic [XLEN-1:0] RESET_PC    = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic            ret_fire,
  input  logic [XLEN-1:0] link_q,
  input  logic [XLEN-1:0] spsr_q,
  input  logic            pc_wr_en,
  input  logic [XLEN-1:0] pc_wr_data,
  input  logic            psr_wr_en,
  input  logic [XLEN-1:0] psr_wr_data,
  output logic [XLEN-1:0] pc_q,
  output logic [XLEN-1:0] cpsr_q,
  output logic            flush_q
);
  localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= RESET_PC;
      cpsr_q  <= psr_at_reset(IBIT_POS);
      flush_q <= 1'b0;
    end else begin
      flush_q <= take;
      if (take) begin
        pc_q   <= VECTOR_ADDR;
        cpsr_q <= psr_after_entry(cpsr_q, IBIT_POS);
      end else if (ret_fire) begin
        pc_q   <= link_q - STEP;
        cpsr_q <= spsr_q;
      end else begin
        if (pc_wr_en)  pc_q   <= pc_wr_data;
        if (psr_wr_en) cpsr_q <= psr_wr_data;
      end
    end
  end

  AST_ENTRY_VECTOR: assert property (@(posedge clk) disable iff (rst)
    take |=> pc_q == VECTOR_ADDR); // R6
  AST_ENTRY_MODE: assert property (@(posedge clk) disable iff (rst)
    take |=> cpsr_q[MODE_W-1:0] == MODE_IRQ && cpsr_q[IBIT_POS]); // R5
  AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (rst)
    flush_q |=> !flush_q); // R7
  AST_RETURN_ATOMIC: assert property (@(posedge clk) disable iff (rst)
    ret_fire |=> pc_q == $past(link_q) - STEP && cpsr_q == $past(spsr_q)); // R8
  AST_NO_DOUBLE_EVENT: assert property (@(posedge clk) disable iff (rst)
    !(take && ret_fire)); // R10
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int unsigned     XLEN        = 32,
  parameter int unsigned     PC_STEP     = 4,
  parameter int unsigned     IBIT_POS    = 7,
  parameter logic [XLEN-1:0] VECTOR_ADDR = 32'h0000_0018,
  parameter logic [XLEN-1:0] RESET_PC    = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            irq_req,
  input  logic            insn_boundary,
  input  logic            ret_req,
  input  logic            pc_wr_en,
  input  logic [XLEN-1:0] pc_wr_data,
  input  logic            psr_wr_en,
  input  logic [XLEN-1:0] psr_wr_data,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] cpsr,
  output logic [XLEN-1:0] irq_link,
  output logic [XLEN-1:0] irq_spsr,
  output logic            flush
);
  logic take;
  logic ret_fire;

  irq_take_detect u_detect (
    .irq_req      (irq_req),
    .insn_boundary(insn_boundary),
    .ret_req      (ret_req),
    .irq_masked   (cpsr[IBIT_POS]),
    .cur_mode     (cpsr[MODE_W-1:0]),
    .take         (take),
    .ret_fire     (ret_fire)
  );

  irq_bank_regs #(.XLEN(XLEN), .PC_STEP(PC_STEP)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .take  (take),
    .pc_q  (pc),
    .cpsr_q(cpsr),
    .link_q(irq_link),
    .spsr_q(irq_spsr)
  );

  irq_psr_pc_unit #(
    .XLEN(XLEN), .PC_STEP(PC_STEP), .IBIT_POS(IBIT_POS),
    .VECTOR_ADDR(VECTOR_ADDR), .RESET_PC(RESET_PC)
  ) u_state (
    .clk        (clk),
    .rst        (rst),
    .take       (take),
    .ret_fire   (ret_fire),
    .link_q     (irq_link),
    .spsr_q     (irq_spsr),
    .pc_wr_en   (pc_wr_en),
    .pc_wr_data (pc_wr_data),
    .psr_wr_en  (psr_wr_en),
    .psr_wr_data(psr_wr_data),
    .pc_q       (pc),
    .cpsr_q     (cpsr),
    .flush_q    (flush)
  );

  AST_MASKED_NO_ENTRY: assert property (@(posedge clk) disable iff (rst)
    cpsr[IBIT_POS] |=> !flush); // R2
endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq_req = 0, insn_boundary = 0, ret_req = 0;
  logic        pc_wr_en = 0, psr_wr_en = 0;
  logic [31:0] pc_wr_data = 0, psr_wr_data = 0;
  logic [31:0] pc, cpsr, irq_link, irq_spsr;
  logic        flush;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  logic [31:0] m_pc, m_cpsr, m_link, m_spsr;
  logic        m_flush;

  always #10 clk = ~clk; // 50 MHz

  irq_entry_seq u_dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .insn_boundary(insn_boundary),
    .ret_req(ret_req), .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data),
    .psr_wr_en(psr_wr_en), .psr_wr_data(psr_wr_data), .pc(pc), .cpsr(cpsr),
    .irq_link(irq_link), .irq_spsr(irq_spsr), .flush(flush)
  );

  always @(posedge clk) begin
    bit go_in, go_back;
    if (rst) begin
      m_pc = 0; m_cpsr = 32'h93; m_link = 0; m_spsr = 0; m_flush = 0;
    end else begin
      go_in   = irq_req && insn_boundary && !m_cpsr[7];
      go_back = !go_in && ret_req && (m_cpsr[4:0] == 5'b10010);
      m_flush = go_in;
      if (go_in) begin
        m_link = m_pc + 32'd4;
        m_spsr = m_cpsr;
        m_pc   = 32'h18;
        m_cpsr = {m_cpsr[31:8], 1'b1, m_cpsr[6:5], 5'b10010};
      end else if (go_back) begin
        m_pc   = m_link - 32'd4;
        m_cpsr = m_spsr;
      end else begin
        if (pc_wr_en)  m_pc   = pc_wr_data;
        if (psr_wr_en) m_cpsr = psr_wr_data;
      end
    end
  end

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check32("R6/R8/R9/R10 pc", pc, m_pc);
    check32("R2/R5/R8/R9 cpsr", cpsr, m_cpsr);
    check32("R3/R11 link", irq_link, m_link);
    check32("R4/R11 spsr", irq_spsr, m_spsr);
    check32("R7 flush", {31'd0, flush}, {31'd0, m_flush});
  endtask

  task automatic cyc(input bit i, input bit b, input bit r, input bit pw,
                     input logic [31:0] pd, input bit sw, input logic [31:0] sd);
    irq_req = i; insn_boundary = b; ret_req = r;
    pc_wr_en = pw; pc_wr_data = pd; psr_wr_en = sw; psr_wr_data = sd;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check32("R1 pc", pc, 32'h0);
    check32("R1 cpsr", cpsr, 32'h93);
    check32("R1 link", irq_link, 32'h0);
    check32("R1 spsr", irq_spsr, 32'h0);
    check32("R1 flush", {31'd0, flush}, 32'h0);
    // R2: masked request, and request without boundary
    cyc(1, 1, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 1, 32'h100, 1, 32'h10);   // user mode, unmasked
    cyc(1, 0, 0, 0, 0, 0, 0);              // no boundary: ignored
    // R9: return outside interrupt mode
    cyc(0, 0, 1, 0, 0, 0, 0);
    check32("R9 pc", pc, 32'h100);
    // entry: R3 R4 R5 R6 R7
    cyc(1, 1, 0, 0, 0, 0, 0);
    check32("R6 vector", pc, 32'h18);
    check32("R3 link", irq_link, 32'h104);
    check32("R4 spsr", irq_spsr, 32'h10);
    check32("R5 cpsr", cpsr, 32'h92);
    check32("R7 flush high", {31'd0, flush}, 32'h1);
    cyc(0, 0, 0, 0, 0, 0, 0);
    check32("R7 flush low", {31'd0, flush}, 32'h0);
    // R10: return beats writes at the same edge; R8 atomic restore
    cyc(0, 0, 1, 1, 32'hDEAD, 1, 32'h55);
    check32("R8 pc", pc, 32'h100);
    check32("R8 cpsr", cpsr, 32'h10);
    // R3 wrap: pc = FFFF_FFFC gives link 0
    cyc(0, 0, 0, 1, 32'hFFFF_FFFC, 0, 0);
    cyc(1, 1, 1, 1, 32'h44, 0, 0);         // R10 entry wins
    check32("R3 wrap link", irq_link, 32'h0);
    check32("R10 pc", pc, 32'h18);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] sd;
      sd = $urandom;
      if (($urandom % 2) == 0) sd[4:0] = 5'b10010;
      cyc(($urandom % 3) == 0, ($urandom % 2) == 0, ($urandom % 4) == 0,
          ($urandom % 5) == 0, $urandom, ($urandom % 8) == 0, sd);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule